// File: doc/BRIEF.md
# TLB Replacement Index Generator

This block picks a TLB entry to overwrite when a write to a random entry is requested. It holds a 32-bit linear congruential seed. Each accepted request advances the seed once. A slice of the advanced seed is then reduced into the range of entries that are not wired, meaning the entries from the current wired count up to the last entry. Entries below the wired count are never chosen.

The range reduction is done by a shift-and-subtract divider that handles one bit per clock. The result therefore appears a fixed number of cycles after the request is accepted. The index and its valid flag stay on the outputs until the next accepted request. A wired count at or above the entry count selects the top entry. The TLB array itself is outside this block.

Top module: `tlb_rand_index`

## Requirements
- R1: Reset, whether at start-up or in the middle of a computation, drives `idxValid` low and `randIdx` to 0, and returns the seed to 0. The first request after reset therefore returns exactly the wired value it was given.
- R2: Each accepted request replaces the seed with seed × 314159 + 1, modulo 2^32. Starting from reset, the second request with a wired value of 0 returns index 4.
- R3: The returned index is (bits [31:16] of the advanced seed) mod (N − W) + W. Here N is the entry count (default 16) and W is the wired value captured with the request.
- R4: When W < N, a valid index is never below W.
- R5: A request is accepted on a clock edge where the block is idle and `reqStrobe` is high. On that edge `idxValid` goes low. It goes high on the 16th rising edge after the accepting edge and stays high until the next accepted request.
- R6: A request that arrives while a computation is running is ignored. It neither advances the seed nor restarts or delays the running computation.
- R7: When W ≥ N, the index is N − 1.
- R8: W is captured on the accepting edge. Changes to `wiredIn` during the computation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqStrobe | input | 1 | Request for a new index |
| wiredIn | input | IDX_W+1 | Count of wired (protected) entries |
| randIdx | output | IDX_W | Selected entry index |
| idxValid | output | 1 | High while randIdx holds a finished result |

## Verification
The hardest situation to reach from the ports is a request that lands in the middle of a running computation, especially when `wiredIn` also moves at the same time. The only evidence that the request was discarded is the index produced on the following request. The stimulus table therefore includes rows that pulse `reqStrobe` five cycles into a run, and rows that change `wiredIn` right after acceptance. The bench model advances its seed only on accepted requests and uses the captured wired value. A mid-run reset followed by a request confirms that the seed returns to zero.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  // strobes from sequencing control into the datapath
  typedef struct packed {
    logic start;   // accept request: advance seed, load divider
    logic step;    // one divider iteration
    logic finish;  // last iteration: publish index
  } randStrb_t;
endpackage

// File: rtl/tlb_rand_ctrl.sv
module tlb_rand_ctrl
  import tlb_rand_pkg::*;
#(
  parameter int ITER = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqStrobe,
  output randStrb_t strb
);
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;

  typedef enum logic {IDLE, RUN} ctrlState_t;
  ctrlState_t stateQ;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    strb.start  = (stateQ == IDLE) && reqStrobe;
    strb.step   = (stateQ == RUN);
    strb.finish = (stateQ == RUN) && (cntQ == CNT_W'(ITER - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= IDLE;
      cntQ   <= '0;
    end else if (strb.start) begin
      stateQ <= RUN;
      cntQ   <= '0;
    end else if (strb.finish) begin
      stateQ <= IDLE;
      cntQ   <= '0;
    end else if (strb.step) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  AST_RUN_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (strb.step && !strb.start)); // R6
  AST_IDLE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !strb.step); // R5
endmodule

// File: rtl/tlb_rand_dp.sv
module tlb_rand_dp
  import tlb_rand_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4,
  parameter int WIRED_W     = 5,
  parameter int SEED_W      = 32,
  parameter int SLICE_LO    = 16,
  parameter int SLICE_W     = 16,
  parameter int LCG_MUL     = 314159,
  parameter int LCG_INC     = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  randStrb_t          strb,
  input  logic [WIRED_W-1:0] wiredIn,
  output logic [IDX_W-1:0]   randIdx,
  output logic               idxValid
);
  localparam int REM_W = WIRED_W + 1;
  localparam logic [REM_W-1:0] N_ENT = REM_W'(NUM_ENTRIES);

  logic [SEED_W-1:0]  seedQ, seedNext;
  logic [SLICE_W-1:0] divQ;
  logic [REM_W-1:0]   remQ, remShift, remNew, span, wiredExt;
  logic [WIRED_W-1:0] wiredQ;
  logic               clampQ;
  logic [IDX_W-1:0]   finalIdx;

  // seed advance and range selection
  always_comb begin
    seedNext = seedQ * SEED_W'(LCG_MUL) + SEED_W'(LCG_INC);
    wiredExt = {1'b0, wiredQ};
    clampQ   = (wiredExt >= N_ENT);
    span     = clampQ ? REM_W'(1) : (N_ENT - wiredExt);
  end

  // one restoring-division step per cycle
  always_comb begin
    remShift = {remQ[REM_W-2:0], divQ[SLICE_W-1]};
    remNew   = (remShift >= span) ? (remShift - span) : remShift;
    finalIdx = clampQ ? IDX_W'(NUM_ENTRIES - 1) : IDX_W'(remNew + wiredExt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedQ    <= '0;
      divQ     <= '0;
      remQ     <= '0;
      wiredQ   <= '0;
      randIdx  <= '0;
      idxValid <= 1'b0;
    end else if (strb.start) begin
      seedQ    <= seedNext;
      divQ     <= seedNext[SLICE_LO +: SLICE_W];
      remQ     <= '0;
      wiredQ   <= wiredIn;
      idxValid <= 1'b0;
    end else if (strb.step) begin
      remQ <= remNew;
      divQ <= {divQ[SLICE_W-2:0], 1'b0};
      if (strb.finish) begin
        randIdx  <= finalIdx;
        idxValid <= 1'b1;
      end
    end
  end

  AST_IDX_NOT_WIRED: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && !clampQ) |-> ({{(REM_W-IDX_W){1'b0}}, randIdx} >= wiredExt)); // R4
  AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && clampQ) |-> (randIdx == IDX_W'(NUM_ENTRIES - 1))); // R7
  AST_SEED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.start |=> $stable(seedQ)); // R6
  AST_REM_BELOW_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (remQ < span)); // R3
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idxValid) |-> $past(strb.finish)); // R5
endmodule

// File: rtl/tlb_rand_index.sv
module tlb_rand_index
  import tlb_rand_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int WIRED_W     = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqStrobe,
  input  logic [WIRED_W-1:0] wiredIn,
  output logic [IDX_W-1:0]   randIdx,
  output logic               idxValid
);
  localparam int SLICE_W = 16;

  randStrb_t strb;

  tlb_rand_ctrl #(.ITER(SLICE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .strb(strb)
  );

  tlb_rand_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .WIRED_W(WIRED_W),
    .SEED_W(32), .SLICE_LO(16), .SLICE_W(SLICE_W),
    .LCG_MUL(314159), .LCG_INC(1)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wiredIn(wiredIn),
    .randIdx(randIdx), .idxValid(idxValid)
  );
endmodule

// File: tb/tlb_rand_index_test.sv
module tlb_rand_index_test;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int WW = 5;
  localparam int NV = 12;
  // columns: wired at request, wired during run, pulse request mid-run
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{3, 3, 0}, '{8, 8, 0}, '{15, 15, 0},
    '{1, 9, 0},   // R8 wired moves
    '{12, 2, 1},  // R6 and R8
    '{16, 16, 0}, // R7 boundary
    '{31, 0, 0},  // R7 maximum
    '{5, 5, 1},   // R6
    '{14, 14, 0}, '{7, 7, 0},
    '{0, 31, 1}
  };

  logic clk = 1'b0, rstN = 1'b0, reqStrobe = 1'b0;
  logic [WW-1:0] wiredIn = '0;
  logic [IW-1:0] randIdx;
  logic idxValid;
  int checks = 0, fails = 0;
  logic [31:0] seedM = '0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_rand_index #(.NUM_ENTRIES(N)) uut (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .wiredIn(wiredIn),
    .randIdx(randIdx), .idxValid(idxValid)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expIdx(logic [31:0] s, int w);
    if (w >= N) return N - 1;
    return int'(s[31:16]) % (N - w) + w;
  endfunction

  task automatic runReq(int w, int wMid, bit poke, string tag);
    @(negedge clk); reqStrobe = 1'b1; wiredIn = WW'(w);
    @(negedge clk); reqStrobe = 1'b0; wiredIn = WW'(wMid);
    seedM = seedM * 32'd314159 + 32'd1;
    chk({"R5 cleared on accept ", tag}, idxValid, 0);
    for (int c = 1; c < 16; c++) begin
      reqStrobe = (poke && c == 5);
      @(negedge clk);
    end
    reqStrobe = 1'b0;
    chk({"R5 not yet valid ", tag}, idxValid, 0);
    @(negedge clk);
    chk({"R5 valid ", tag}, idxValid, 1);
    chk({"R3 R4 index ", tag}, randIdx, expIdx(seedM, w));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", idxValid, 0);
    chk("R1 reset index", randIdx, 0);
    rstN = 1'b1;

    // R1 and R2 directed: seed 1 then 314160
    runReq(0, 0, 0, "R1 first after reset");
    chk("R1 first index equals wired", randIdx, 0);
    runReq(0, 0, 0, "R2 second");
    chk("R2 second index literal", randIdx, 4);
    @(negedge clk);
    chk("R5 valid held", idxValid, 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vec%0d", i);
      if (VEC[i][2] != 0) tag = {tag, " R6"};
      if (VEC[i][0] != VEC[i][1]) tag = {tag, " R8"};
      if (VEC[i][0] >= N) tag = {tag, " R7"};
      runReq(VEC[i][0], VEC[i][1], VEC[i][2] != 0, tag);
    end

    // R1 mid-run reset
    @(negedge clk); reqStrobe = 1'b1; wiredIn = 5'd2;
    @(negedge clk); reqStrobe = 1'b0;
    repeat (6) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset valid", idxValid, 0);
    chk("R1 mid-run reset index", randIdx, 0);
    rstN = 1'b1;
    seedM = '0;
    runReq(6, 6, 0, "R1 reseeded");
    chk("R1 reseeded index equals wired", randIdx, 6);
    runReq(15, 15, 1, "R7 edge span one R6");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule